// File: doc/BRIEF.md
# Multi-Bank SDRAM Access Scheduler with Concurrent Auto Precharge

This block sits on the controller side of a multi-bank synchronous DRAM. It turns a stream of column requests into READ and WRITE commands, with or without auto precharge. A request names a bank, a column, the direction and whether the bank should close after the access. Row activation, refresh, mode programming and pad timing are handled elsewhere. Any bank that is not bursting and not precharging is treated as ready for a column command.

The device closes a bank on its own after an auto-precharge access, and it permits concurrent auto precharge. The scheduler uses this. A command to a second bank may be issued while a burst is still running on the first bank. The interrupted bank then begins its precharge in the very cycle the interrupting command appears on the bus. Each bank holds its own state: `BK_IDLE`, `BK_OPEN`, `BK_READ`, `BK_WRITE` or `BK_PRECH`. Each bank also has its own precharge recovery counter.

Read data timing is tracked by a CAS-latency pipeline that is tagged with the bank. The pipeline is followed by a beat counter, and the counter drives a read-valid strobe and the bank of each beat. A write that arrives while read data is still pending is handled by a small phase machine. It moves from `PH_RUN` to `PH_MASK_A` when the write is seen, then from `PH_MASK_A` to `PH_MASK_B`, and then from `PH_MASK_B` back to `PH_RUN` as the write issues. While it is in the two mask phases it raises DQM, so the outgoing read data cannot collide with the write data.

Top module: `sdram_cap_sched`

## Requirements
- R1: After reset the command bus shows NOP, `dqm` and `rd_valid` are low, every bank is idle, and a request to any bank is accepted in its first cycle.
- R2: Command codes are 2'b00 NOP, 2'b01 READ and 2'b10 WRITE. A request that is accepted at a clock edge (`req_valid` and `req_ready` both high) appears on `cmd_code`, `cmd_bank`, `cmd_col` and `cmd_ap` in the cycle that follows. NOP is driven in every other cycle.
- R3: A READ shown in cycle T produces `rd_valid` high in cycles T+CAS_LAT through T+CAS_LAT+BURST_LEN-1, with `rd_bank` equal to the READ's bank.
- R4: A READ or WRITE to a different bank is accepted while a burst is running, so two back-to-back commands can issue one cycle apart. A READ that interrupts a READ ends the earlier beats where the new beats begin, CAS_LAT cycles after the new READ.
- R5: A request to a bank that is still within the BURST_LEN cycles of its own command is held with `req_ready` low. Without auto precharge, the next command to that bank issues BURST_LEN+1 cycles after the first one.
- R6: A bank whose burst with auto precharge runs to completion begins precharging BURST_LEN cycles after its command. It becomes usable after T_RP more cycles, so a waiting request to it issues exactly BURST_LEN+T_RP+1 cycles after the first command.
- R7: A bank with auto precharge that is interrupted in cycle T' begins precharging in T'. A waiting request to it issues at T'+T_RP+1.
- R8: A WRITE requested while read data is pending (in the latency pipeline or still being delivered) issues three cycles after the request is presented. `dqm` is high in exactly the two cycles before the WRITE and low in the WRITE cycle.
- R9: A WRITE cancels all pending read beats, so `rd_valid` is low from the WRITE cycle onward, up to any later READ.
- R10: A WRITE with no read data pending issues in the cycle after the request, with `dqm` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; must be held until accepted |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = WRITE, 0 = READ |
| req_ap | input | 1 | Close the bank automatically after the burst |
| req_ready | output | 1 | Request is accepted at the coming edge |
| cmd_code | output | 2 | Command code (NOP/READ/WRITE) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_col | output | COL_W | Column of the command |
| cmd_ap | output | 1 | Auto-precharge flag of the command |
| dqm | output | 1 | Data mask strobe |
| rd_valid | output | 1 | A read beat is on the data bus this cycle |
| rd_bank | output | BANK_W | Bank the current read beat belongs to |

## Verification
The bench covers every ordered pair of distinct banks, under every combination of read and write for the first and the second access. In each case it measures when the interrupted bank can accept a command again. A design that started the precharge at the natural end of the burst, and not at the interrupting command, would issue that bank's next command late. A design that ignored the interruption would block the second bank entirely. The bench also moves a WRITE across every offset of a pending read burst. At these offsets a wrong DQM window, a missing stall, or read beats that survive the write show up as misplaced strobes or misplaced issue cycles. A per-cycle model of the command bus and of the read-valid stream catches any stray command or any beat with the wrong bank.

// File: rtl/sdram_cap_pkg.sv
package sdram_cap_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_OPEN,
        BK_READ,
        BK_WRITE,
        BK_PRECH
    } bank_st_e;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_MASK_A,
        PH_MASK_B
    } phase_e;

endpackage

// File: rtl/cap_bank_ctl.sv
module cap_bank_ctl
    import sdram_cap_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic issue_wr,
    input  logic issue_ap,
    input  logic other_issue,
    output logic busy,
    output logic bursting
);
    localparam int MAXC  = (BURST_LEN > T_RP) ? BURST_LEN : T_RP;
    localparam int CNT_W = $clog2(MAXC + 1);

    bank_st_e         st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             ap_q, ap_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= BK_IDLE;
            cnt  <= '0;
            ap_q <= 1'b0;
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            ap_q <= ap_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        ap_nx  = ap_q;
        unique case (st)
            BK_IDLE, BK_OPEN: begin
                if (issue) begin
                    st_nx  = issue_wr ? BK_WRITE : BK_READ;
                    cnt_nx = CNT_W'(BURST_LEN - 1);
                    ap_nx  = issue_ap;
                end
            end
            BK_READ, BK_WRITE: begin
                if (other_issue || cnt == '0) begin
                    if (ap_q) begin
                        st_nx  = BK_PRECH;
                        cnt_nx = CNT_W'(T_RP - 1);
                    end else begin
                        st_nx = BK_OPEN;
                    end
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            BK_PRECH: begin
                if (cnt == '0) st_nx = BK_IDLE;
                else           cnt_nx = cnt - CNT_W'(1);
            end
            default: st_nx = BK_IDLE;
        endcase
    end

    always_comb begin
        bursting = (st == BK_READ) || (st == BK_WRITE);
        busy     = bursting || (st == BK_PRECH);
    end

    assert_issue_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !busy);

    assert_intr_prech_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bursting && other_issue && ap_q) |=> (st == BK_PRECH));

    assert_prech_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_PRECH && cnt == '0) |=> (st == BK_IDLE));

endmodule

// File: rtl/cap_read_track.sv
module cap_read_track #(
    parameter int BANK_W    = 2,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BANK_W-1:0] launch_bank,
    input  logic              flush,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_bank,
    output logic              pending
);
    localparam int BT_W = $clog2(BURST_LEN + 1);

    logic [CAS_LAT-1:0] pv;
    logic [BANK_W-1:0]  pb [CAS_LAT];
    logic [BT_W-1:0]    beats;
    logic [BANK_W-1:0]  beat_bank;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pv        <= '0;
            beats     <= '0;
            beat_bank <= '0;
            for (int k = 0; k < CAS_LAT; k++) pb[k] <= '0;
        end else begin
            pv[0] <= launch;
            pb[0] <= launch_bank;
            for (int k = 1; k < CAS_LAT; k++) begin
                pv[k] <= pv[k-1];
                pb[k] <= pb[k-1];
            end
            if (pv[CAS_LAT-1]) begin
                beats     <= BT_W'(BURST_LEN);
                beat_bank <= pb[CAS_LAT-1];
            end else if (beats != '0) begin
                beats <= beats - BT_W'(1);
            end
        end
    end

    always_comb begin
        rd_valid = (beats != '0);
        rd_bank  = beat_bank;
        pending  = (|pv) || rd_valid;
    end

    assert_flush_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pending);

endmodule

// File: rtl/sdram_cap_sched.sv
module sdram_cap_sched
    import sdram_cap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 10,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_ap,
    output logic              req_ready,
    output logic [1:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              dqm,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_bank
);
    phase_e                 phase, phase_nx;
    logic                   accept, legal, rd_pend;
    logic [NUM_BANKS-1:0]   bank_busy, bank_burst, issue_vec, other_vec;

    // bank targeting
    always_comb begin
        accept = req_valid && req_ready;
        for (int b = 0; b < NUM_BANKS; b++) begin
            issue_vec[b] = accept && (req_bank == BANK_W'(b));
            other_vec[b] = accept && (req_bank != BANK_W'(b));
        end
        legal = !bank_busy[req_bank];
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        cap_bank_ctl #(
            .BURST_LEN (BURST_LEN),
            .T_RP      (T_RP)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue       (issue_vec[g]),
            .issue_wr    (req_write),
            .issue_ap    (req_ap),
            .other_issue (other_vec[g]),
            .busy        (bank_busy[g]),
            .bursting    (bank_burst[g])
        );
    end

    cap_read_track #(
        .BANK_W    (BANK_W),
        .CAS_LAT   (CAS_LAT),
        .BURST_LEN (BURST_LEN)
    ) u_rdtrk (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (accept && !req_write),
        .launch_bank (req_bank),
        .flush       (accept && req_write),
        .rd_valid    (rd_valid),
        .rd_bank     (rd_bank),
        .pending     (rd_pend)
    );

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_RUN;
        else        phase <= phase_nx;
    end

    always_comb begin
        phase_nx  = phase;
        req_ready = 1'b0;
        unique case (phase)
            PH_RUN: begin
                req_ready = legal && !(req_write && rd_pend);
                if (req_valid && req_write && rd_pend && legal) phase_nx = PH_MASK_A;
            end
            PH_MASK_A: phase_nx = PH_MASK_B;
            PH_MASK_B: begin
                req_ready = legal;
                phase_nx  = PH_RUN;
            end
            default: phase_nx = PH_RUN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code <= CMD_NOP;
            cmd_bank <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
            dqm      <= 1'b0;
        end else begin
            dqm <= (phase_nx == PH_MASK_A) || (phase_nx == PH_MASK_B);
            if (accept) begin
                cmd_code <= req_write ? CMD_WR : CMD_RD;
                cmd_bank <= req_bank;
                cmd_col  <= req_col;
                cmd_ap   <= req_ap;
            end else begin
                cmd_code <= CMD_NOP;
                cmd_bank <= '0;
                cmd_col  <= '0;
                cmd_ap   <= 1'b0;
            end
        end
    end

    assert_single_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_burst));

    assert_guard_dqm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MASK_B && accept) |=> (cmd_code == CMD_WR && !dqm && $past(dqm, 2)));

    assert_write_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_WR) |-> !rd_valid);

endmodule

// File: tb/test_sdram_cap_sched.sv
module test_sdram_cap_sched;
    localparam int NB = 4;
    localparam int BW = 2;
    localparam int CW = 10;
    localparam int CL = 3;
    localparam int BL = 4;
    localparam int RP = 3;
    localparam int HZ = 16384;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, req_valid, req_write, req_ap, req_ready;
    logic [BW-1:0] req_bank, cmd_bank, rd_bank;
    logic [CW-1:0] req_col, cmd_col;
    logic [1:0]    cmd_code;
    logic          cmd_ap, dqm, rd_valid;

    sdram_cap_sched #(.NUM_BANKS(NB), .COL_W(CW), .CAS_LAT(CL), .BURST_LEN(BL), .T_RP(RP))
    i_sdram_cap_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_write(req_write), .req_ap(req_ap), .req_ready(req_ready),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .dqm(dqm), .rd_valid(rd_valid), .rd_bank(rd_bank)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit exp_rv [HZ];
    int exp_rb [HZ];
    int exp_cmd[HZ];
    int exp_cb [HZ];
    int exp_cc [HZ];
    int exp_ca [HZ];
    bit dqm_h  [HZ];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // per-cycle model comparison (R2, R3)
    always @(negedge clk) begin
        if (mon_on && cyc < HZ) begin
            dqm_h[cyc] = dqm;
            chk(rd_valid == exp_rv[cyc], "R3 rd_valid", int'(rd_valid), int'(exp_rv[cyc]));
            if (exp_rv[cyc] && rd_valid)
                chk(int'(rd_bank) == exp_rb[cyc], "R3 rd_bank", int'(rd_bank), exp_rb[cyc]);
            chk(int'(cmd_code) == exp_cmd[cyc], "R2 cmd_code", int'(cmd_code), exp_cmd[cyc]);
            if (exp_cmd[cyc] != 0 && int'(cmd_code) == exp_cmd[cyc]) begin
                chk(int'(cmd_bank) == exp_cb[cyc], "R2 cmd_bank", int'(cmd_bank), exp_cb[cyc]);
                chk(int'(cmd_col) == exp_cc[cyc], "R2 cmd_col", int'(cmd_col), exp_cc[cyc]);
                chk(int'(cmd_ap) == exp_ca[cyc], "R2 cmd_ap", int'(cmd_ap), exp_ca[cyc]);
            end
        end
    end

    // present a request at a falling edge; return request and issue cycles
    task automatic issue(input int b, input int col, input bit wr, input bit ap,
                         output int c, output int t);
        bit rdy;
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_col   = CW'(col);
        req_write = wr;
        req_ap    = ap;
        c = cyc;
        t = -1;
        for (int i = 0; i < 200; i++) begin
            #1;
            rdy = req_ready;
            @(posedge clk);
            #1;
            if (rdy) begin
                t = cyc;
                break;
            end
            @(negedge clk);
        end
        if (t < 0) begin
            chk(1'b0, "R5 request never accepted", 0, 1);
        end else if (t + CL + 2 * BL < HZ) begin
            exp_cmd[t] = wr ? 2 : 1;
            exp_cb[t]  = b;
            exp_cc[t]  = col;
            exp_ca[t]  = int'(ap);
            if (wr) begin
                for (int k = t; k <= t + CL + BL; k++) exp_rv[k] = 1'b0;
            end else begin
                for (int k = 0; k < BL; k++) begin
                    exp_rv[t + CL + k] = 1'b1;
                    exp_rb[t + CL + k] = b;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int c, t, c2, t2, c3, t3, t1, ps, cols[4];
        bit guarded;
        rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0;
        req_write = 1'b0; req_ap = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_code == 2'b00, "R1 reset command", int'(cmd_code), 0);
        chk(dqm == 1'b0, "R1 reset dqm", int'(dqm), 0);
        chk(rd_valid == 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
        mon_on = 1'b1;

        // R1/R2/R3: single reads on each bank, varied columns
        for (int b = 0; b < NB; b++) begin
            cols[0] = 0; cols[1] = 1023; cols[2] = 682; cols[3] = b * 97 + 5;
            for (int j = 0; j < 4; j++) begin
                issue(b, cols[j], 1'b0, j[0], c, t);
                chk(t == c + 1, "R1 idle bank accepts at once", t - c, 1);
                idle(CL + BL + RP + 2);
            end
        end

        // R5/R6: same-bank follow-up, with and without auto precharge
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < 2; w++)
                for (int a = 0; a < 2; a++) begin
                    idle(20);
                    issue(b, 16 * b + w, w[0], a[0], c, t1);
                    if (w == 1) chk(dqm_h[t1 - 1] == 1'b0, "R10 no mask for lone write", int'(dqm_h[t1 - 1]), 0);
                    issue(b, 33, 1'b0, 1'b0, c2, t2);
                    if (a == 1) chk(t2 == t1 + BL + RP + 1, "R6 precharge recovery", t2 - t1, BL + RP + 1);
                    else        chk(t2 == t1 + BL + 1, "R5 same-bank hold", t2 - t1, BL + 1);
                end

        // R4/R7/R8/R10: every ordered bank pair, every direction mix
        for (int n = 0; n < NB; n++)
            for (int m = 0; m < NB; m++) begin
                if (m == n) continue;
                for (int w1 = 0; w1 < 2; w1++)
                    for (int w2 = 0; w2 < 2; w2++) begin
                        idle(20);
                        issue(n, 100 + m, w1[0], 1'b1, c, t1);
                        guarded = (w2 == 1) && (w1 == 0);
                        issue(m, 200 + n, w2[0], 1'b0, c2, t2);
                        chk(t2 == c2 + (guarded ? 3 : 1), "R4 other bank issues during burst", t2 - c2, guarded ? 3 : 1);
                        if (guarded) begin
                            chk(dqm_h[t2 - 1] && dqm_h[t2 - 2] && !dqm_h[t2 - 3], "R8 mask window",
                                int'({dqm_h[t2 - 3], dqm_h[t2 - 2], dqm_h[t2 - 1]}), 3);
                            chk(dqm == 1'b0, "R8 mask low at write", int'(dqm), 0);
                        end else if (w2 == 1) begin
                            chk(dqm_h[t2 - 1] == 1'b0, "R10 write without mask", int'(dqm_h[t2 - 1]), 0);
                        end
                        ps = (t1 + BL < t2) ? t1 + BL : t2;
                        issue(n, 300, 1'b0, 1'b0, c3, t3);
                        chk(t3 == ps + RP + 1, "R7 interrupted bank recovery", t3 - t2, ps + RP + 1 - t2);
                    end
            end

        // R8/R9/R10: write placed at every offset of a pending read burst
        for (int d = 0; d <= CL + BL + 1; d++) begin
            idle(20);
            issue(0, 7 * d, 1'b0, 1'b0, c, t1);
            idle(d);
            guarded = (d < CL + BL);
            issue(1, 9, 1'b1, 1'b0, c2, t2);
            chk(t2 == c2 + (guarded ? 3 : 1), "R8 write stall length", t2 - c2, guarded ? 3 : 1);
            chk(rd_valid == 1'b0, "R9 beats cancelled by write", int'(rd_valid), 0);
            if (!guarded) chk(dqm_h[t2 - 1] == 1'b0, "R10 write after drain unmasked", int'(dqm_h[t2 - 1]), 0);
        end

        idle(20);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule